// File: doc/BRIEF.md
# Program Counter and Return Stack Sequencer

This block holds the instruction address of a small processor and keeps its subroutine return stack in ordinary data memory. Each cycle it can take one control request from the decoder. It can advance to the next instruction by one or two words, load a jump target, enter a subroutine or an interrupt handler, or return from either. The program counter always names the next instruction to fetch.

Calls and interrupt entry save a return address on a stack that grows downward in data SRAM. The address goes one byte per cycle through a byte-wide memory port. Returns read it back the same way. The stack pointer resets to the highest SRAM address. Software can read it, and can write its low and high bytes separately.

While a save or restore is in progress the block reports busy and ignores every new request.

Top module: `pc_stack_unit`

## Requirements
- R1: After reset the program counter is 0, the stack pointer equals the parameter `SP_TOP`, `busy_o` and `irq_en_o` are low, and no memory access is issued.
- R2: A step request advances the program counter by 1, or by 2 when `two_word_i` is 1, in the cycle after it is accepted. The addition wraps modulo 2^PC_W.
- R3: A jump request loads `target_i` into the program counter in the cycle after it is accepted.
- R4: A call saves the return address, which is the program counter plus the current instruction length. The low byte is written at SP and the high byte at SP-1, in two successive busy cycles. SP then ends 2 lower and the program counter equals `target_i`.
- R5: An interrupt request saves the current, unadvanced program counter in the same way as R4 and loads `vector_i`.
- R6: A return reads SP+1 and then SP+2, one per cycle. Memory returns read data one cycle after the read strobe. The first byte read is the high byte. After three busy cycles the program counter holds the restored address and SP is 2 higher.
- R7: A return-from-interrupt behaves as R6 and additionally drives `irq_en_o` high for exactly one cycle, the cycle after the restore. A plain return never raises it.
- R8: When idle, `sp_wr_lo_i` writes `sp_wdata_i` into SP bits 7:0 and `sp_wr_hi_i` writes it into the upper bits. The new value is visible on `sp_o` in the next cycle and is used by the next call.
- R9: While `busy_o` is high, all requests and stack pointer writes are ignored. The program counter changes only on the final cycle of the sequence.
- R10: When several requests arrive together, exactly one is taken, in the priority order interrupt, call, return, return-from-interrupt, jump, step.
- R11: Write and read strobes are never active in the same cycle. A write targets SP and a read targets SP+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Advance to next sequential instruction |
| two_word_i | input | 1 | Current instruction occupies two words |
| jump_i | input | 1 | Load jump target |
| call_i | input | 1 | Subroutine call to target |
| ret_i | input | 1 | Return from subroutine |
| reti_i | input | 1 | Return from interrupt handler |
| irq_i | input | 1 | Enter interrupt handler at vector |
| target_i | input | PC_W | Jump or call destination |
| vector_i | input | PC_W | Interrupt handler address |
| sp_wr_lo_i | input | 1 | Write low byte of stack pointer |
| sp_wr_hi_i | input | 1 | Write high bits of stack pointer |
| sp_wdata_i | input | 8 | Stack pointer write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after read strobe |
| pc_o | output | PC_W | Address of next instruction |
| sp_o | output | SP_W | Stack pointer |
| busy_o | output | 1 | Save or restore in progress |
| irq_en_o | output | 1 | One-cycle interrupt re-enable pulse |
| mem_addr_o | output | SP_W | Memory byte address |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_wdata_o | output | 8 | Memory write data |

## Verification
The bench builds the block with a 16-bit program counter, a 16-bit stack pointer and `SP_TOP` set to 0x01FF. A 512-byte memory model therefore covers every address the stack touches, and the byte order of each saved address can be read back directly. A 16-bit counter lets a jump to 0xFFFF exercise wrap-around. Two-byte return addresses mean each save and restore shows both the low-first and high-first orderings. The bench also moves the stack pointer through the byte write port and checks that a following call lands at the new location.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PUSH    = 2'd1,
        ST_POP     = 2'd2,
        ST_POP_END = 2'd3
    } seq_state_e;

endpackage

// File: rtl/pcs_pc.sv
module pcs_pc #(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv_i,
    input  logic            two_word_i,
    input  logic            load_i,
    input  logic [PC_W-1:0] load_val_i,
    output logic [PC_W-1:0] pc_o,
    output logic [PC_W-1:0] pc_plus_o
);

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pc_regs_t;

    pc_regs_t r_d, r_q;
    logic [PC_W-1:0] len;

    always_comb begin
        r_d       = r_q;
        len       = two_word_i ? PC_W'(2) : PC_W'(1);
        pc_plus_o = r_q.pc + len;
        if (load_i) begin
            r_d.pc = load_val_i;
        end else if (adv_i) begin
            r_d.pc = pc_plus_o;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.pc <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pc_o = r_q.pc;

    // R2: a step without a load moves by the encoded length
    p_step_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && !two_word_i) |=> (r_q.pc == $past(r_q.pc) + PC_W'(1)));

endmodule

// File: rtl/pcs_sp.sv
module pcs_sp #(
    parameter int             SP_W   = 16,
    parameter logic [SP_W-1:0] SP_TOP = 16'h0FFF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc_i,
    input  logic            dec_i,
    input  logic            wr_lo_i,
    input  logic            wr_hi_i,
    input  logic [7:0]      wdata_i,
    output logic [SP_W-1:0] sp_o
);

    localparam int HI_W = SP_W - 8;

    typedef struct packed {
        logic [SP_W-1:0] sp;
    } sp_regs_t;

    sp_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (dec_i) begin
            r_d.sp = r_q.sp - SP_W'(1);
        end else if (inc_i) begin
            r_d.sp = r_q.sp + SP_W'(1);
        end else begin
            if (wr_lo_i) begin
                r_d.sp[7:0] = wdata_i;
            end
            if (wr_hi_i) begin
                r_d.sp[SP_W-1:8] = wdata_i[HI_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.sp <= SP_TOP;
        end else begin
            r_q <= r_d;
        end
    end

    assign sp_o = r_q.sp;

    // R4: every saved byte moves the pointer one step down
    p_push_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |=> (r_q.sp == $past(r_q.sp) - SP_W'(1)));

    // R6: every restored byte moves the pointer one step up
    p_pop_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !dec_i) |=> (r_q.sp == $past(r_q.sp) + SP_W'(1)));

endmodule

// File: rtl/pcs_seq.sv
module pcs_seq
    import pcs_pkg::*;
#(
    parameter int PC_W = 16,
    parameter int SP_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq_i,
    input  logic            call_i,
    input  logic            ret_i,
    input  logic            reti_i,
    input  logic            jump_i,
    input  logic            step_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic [PC_W-1:0] pc_plus_i,
    input  logic [PC_W-1:0] target_i,
    input  logic [PC_W-1:0] vector_i,
    input  logic [SP_W-1:0] sp_i,
    input  logic [7:0]      rdata_i,
    output logic            busy_o,
    output logic            pc_adv_o,
    output logic            pc_load_o,
    output logic [PC_W-1:0] pc_load_val_o,
    output logic            sp_inc_o,
    output logic            sp_dec_o,
    output logic            mem_we_o,
    output logic            mem_re_o,
    output logic [SP_W-1:0] mem_addr_o,
    output logic [7:0]      mem_wdata_o,
    output logic            reti_pulse_o
);

    localparam int BYTES = (PC_W + 7) / 8;
    localparam int BUF_W = BYTES * 8;
    localparam int CNT_W = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTES - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [BUF_W-1:0] data;
        logic [PC_W-1:0]  tgt;
        logic             is_reti;
        logic             pulse;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic [BUF_W-1:0] shifted;
    logic [BUF_W-1:0] out_shift;

    always_comb begin
        r_d           = r_q;
        r_d.pulse     = 1'b0;
        pc_adv_o      = 1'b0;
        pc_load_o     = 1'b0;
        pc_load_val_o = target_i;
        sp_inc_o      = 1'b0;
        sp_dec_o      = 1'b0;
        mem_we_o      = 1'b0;
        mem_re_o      = 1'b0;
        mem_addr_o    = sp_i;
        shifted       = {r_q.data[BUF_W-9:0], rdata_i};
        out_shift     = r_q.data >> {r_q.cnt, 3'b000};
        mem_wdata_o   = out_shift[7:0];

        case (r_q.st)
            ST_IDLE: begin
                if (irq_i) begin
                    r_d.data = BUF_W'(pc_i);
                    r_d.tgt  = vector_i;
                    r_d.cnt  = '0;
                    r_d.st   = ST_PUSH;
                end else if (call_i) begin
                    r_d.data = BUF_W'(pc_plus_i);
                    r_d.tgt  = target_i;
                    r_d.cnt  = '0;
                    r_d.st   = ST_PUSH;
                end else if (ret_i || reti_i) begin
                    r_d.is_reti = !ret_i;
                    r_d.cnt     = '0;
                    r_d.st      = ST_POP;
                end else if (jump_i) begin
                    pc_load_o     = 1'b1;
                    pc_load_val_o = target_i;
                end else if (step_i) begin
                    pc_adv_o = 1'b1;
                end
            end
            ST_PUSH: begin
                mem_we_o   = 1'b1;
                mem_addr_o = sp_i;
                sp_dec_o   = 1'b1;
                if (r_q.cnt == LAST) begin
                    pc_load_o     = 1'b1;
                    pc_load_val_o = r_q.tgt;
                    r_d.st        = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_POP: begin
                mem_re_o   = 1'b1;
                mem_addr_o = sp_i + SP_W'(1);
                sp_inc_o   = 1'b1;
                if (r_q.cnt != '0) begin
                    r_d.data = shifted;
                end
                if (r_q.cnt == LAST) begin
                    r_d.st = ST_POP_END;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_POP_END: begin
                pc_load_o     = 1'b1;
                pc_load_val_o = PC_W'(shifted);
                r_d.pulse     = r_q.is_reti;
                r_d.st        = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st      <= ST_IDLE;
            r_q.cnt     <= '0;
            r_q.data    <= '0;
            r_q.tgt     <= '0;
            r_q.is_reti <= 1'b0;
            r_q.pulse   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o       = (r_q.st != ST_IDLE);
    assign reti_pulse_o = r_q.pulse;

    // R11: at most one memory access per cycle
    p_one_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o));

    // R11: writes address the current stack pointer
    p_push_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_addr_o == sp_i));

    // R7: the re-enable pulse lasts one cycle
    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reti_pulse_o |=> !reti_pulse_o);

    // R1: idle sequencer issues no memory traffic
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(mem_we_o || mem_re_o));

endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit #(
    parameter int              PC_W   = 16,
    parameter int              SP_W   = 16,
    parameter logic [SP_W-1:0] SP_TOP = 16'h0FFF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_i,
    input  logic            two_word_i,
    input  logic            jump_i,
    input  logic            call_i,
    input  logic            ret_i,
    input  logic            reti_i,
    input  logic            irq_i,
    input  logic [PC_W-1:0] target_i,
    input  logic [PC_W-1:0] vector_i,
    input  logic            sp_wr_lo_i,
    input  logic            sp_wr_hi_i,
    input  logic [7:0]      sp_wdata_i,
    input  logic [7:0]      mem_rdata_i,
    output logic [PC_W-1:0] pc_o,
    output logic [SP_W-1:0] sp_o,
    output logic            busy_o,
    output logic            irq_en_o,
    output logic [SP_W-1:0] mem_addr_o,
    output logic            mem_we_o,
    output logic            mem_re_o,
    output logic [7:0]      mem_wdata_o
);

    logic            pc_adv;
    logic            pc_load;
    logic [PC_W-1:0] pc_load_val;
    logic [PC_W-1:0] pc_plus;
    logic            sp_inc;
    logic            sp_dec;
    logic            io_lo;
    logic            io_hi;

    assign io_lo = sp_wr_lo_i && !busy_o;
    assign io_hi = sp_wr_hi_i && !busy_o;

    pcs_seq #(
        .PC_W (PC_W),
        .SP_W (SP_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_i         (irq_i),
        .call_i        (call_i),
        .ret_i         (ret_i),
        .reti_i        (reti_i),
        .jump_i        (jump_i),
        .step_i        (step_i),
        .pc_i          (pc_o),
        .pc_plus_i     (pc_plus),
        .target_i      (target_i),
        .vector_i      (vector_i),
        .sp_i          (sp_o),
        .rdata_i       (mem_rdata_i),
        .busy_o        (busy_o),
        .pc_adv_o      (pc_adv),
        .pc_load_o     (pc_load),
        .pc_load_val_o (pc_load_val),
        .sp_inc_o      (sp_inc),
        .sp_dec_o      (sp_dec),
        .mem_we_o      (mem_we_o),
        .mem_re_o      (mem_re_o),
        .mem_addr_o    (mem_addr_o),
        .mem_wdata_o   (mem_wdata_o),
        .reti_pulse_o  (irq_en_o)
    );

    pcs_pc #(
        .PC_W (PC_W)
    ) u_pc (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (pc_adv),
        .two_word_i (two_word_i),
        .load_i     (pc_load),
        .load_val_i (pc_load_val),
        .pc_o       (pc_o),
        .pc_plus_o  (pc_plus)
    );

    pcs_sp #(
        .SP_W   (SP_W),
        .SP_TOP (SP_TOP)
    ) u_sp (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (sp_inc),
        .dec_i   (sp_dec),
        .wr_lo_i (io_lo),
        .wr_hi_i (io_hi),
        .wdata_i (sp_wdata_i),
        .sp_o    (sp_o)
    );

    // R9: program counter holds while a sequence runs, except on its final step
    p_pc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !pc_load) |=> $stable(pc_o));

    // R9: pointer writes from software have no effect during a sequence
    p_sp_io_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !mem_we_o && !mem_re_o) |=> $stable(sp_o));

    // R3: an idle jump lands on its target
    p_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && jump_i && !irq_i && !call_i && !ret_i && !reti_i)
        |=> (pc_o == $past(target_i)));

endmodule

// File: tb/pc_stack_unit_tb.sv
`timescale 1ns/1ps
module pc_stack_unit_tb;

    localparam int PC_W = 16;
    localparam int SP_W = 16;
    localparam logic [SP_W-1:0] TOP = 16'h01FF;

    logic clk = 1'b0;
    logic rst_n;
    logic step_i, two_word_i, jump_i, call_i, ret_i, reti_i, irq_i;
    logic [PC_W-1:0] target_i, vector_i;
    logic sp_wr_lo_i, sp_wr_hi_i;
    logic [7:0] sp_wdata_i;
    logic [7:0] mem_rdata_i;
    logic [PC_W-1:0] pc_o;
    logic [SP_W-1:0] sp_o;
    logic busy_o, irq_en_o, mem_we_o, mem_re_o;
    logic [SP_W-1:0] mem_addr_o;
    logic [7:0] mem_wdata_o;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    logic [7:0] mem [0:511];

    always #2 clk = ~clk;

    pc_stack_unit #(.PC_W(PC_W), .SP_W(SP_W), .SP_TOP(TOP)) u_dut (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .two_word_i(two_word_i),
        .jump_i(jump_i), .call_i(call_i), .ret_i(ret_i), .reti_i(reti_i),
        .irq_i(irq_i), .target_i(target_i), .vector_i(vector_i),
        .sp_wr_lo_i(sp_wr_lo_i), .sp_wr_hi_i(sp_wr_hi_i), .sp_wdata_i(sp_wdata_i),
        .mem_rdata_i(mem_rdata_i), .pc_o(pc_o), .sp_o(sp_o), .busy_o(busy_o),
        .irq_en_o(irq_en_o), .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o),
        .mem_re_o(mem_re_o), .mem_wdata_o(mem_wdata_o)
    );

    // memory model: synchronous write, one-cycle read latency
    always @(posedge clk) begin
        if (mem_we_o) mem[mem_addr_o[8:0]] <= mem_wdata_o;
        if (mem_re_o) mem_rdata_i <= mem[mem_addr_o[8:0]];
        if (irq_en_o) pulses <= pulses + 1;
        if (rst_n && mem_we_o && mem_re_o) begin
            errors <= errors + 1;
            $display("FAIL R11 both strobes act=1 exp=0");
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        step_i = 0; two_word_i = 0; jump_i = 0; call_i = 0; ret_i = 0;
        reti_i = 0; irq_i = 0; sp_wr_lo_i = 0; sp_wr_hi_i = 0;
    endtask

    task automatic go();
        @(negedge clk);
        clear_in();
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy_o) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        chk("R1 pc", pc_o, 0);
        chk("R1 sp", sp_o, TOP);
        chk("R1 busy", busy_o, 0);
        chk("R1 irq_en", irq_en_o, 0);
        chk("R1 strobes", {mem_we_o, mem_re_o}, 0);
    endtask

    task automatic t_step();
        step_i = 1; two_word_i = 0; go();
        chk("R2 step one", pc_o, 16'h0001);
        step_i = 1; two_word_i = 1; go();
        chk("R2 step two", pc_o, 16'h0003);
    endtask

    task automatic t_jump();
        jump_i = 1; target_i = 16'h1234; go();
        chk("R3 jump", pc_o, 16'h1234);
    endtask

    task automatic t_call();
        int n;
        call_i = 1; two_word_i = 1; target_i = 16'h0400; go();
        chk("R4 busy", busy_o, 1);
        chk("R9 pc held", pc_o, 16'h1234);
        wait_idle(n);
        chk("R4 cycles", n, 2);
        chk("R4 pc", pc_o, 16'h0400);
        chk("R4 sp", sp_o, 16'h01FD);
        chk("R4 low byte at sp", mem[9'h1FF], 8'h36);
        chk("R4 high byte below", mem[9'h1FE], 8'h12);
    endtask

    task automatic t_ret();
        int n, p0;
        p0 = pulses;
        ret_i = 1; go();
        wait_idle(n);
        chk("R6 cycles", n, 3);
        chk("R6 pc", pc_o, 16'h1236);
        chk("R6 sp", sp_o, TOP);
        repeat (2) @(negedge clk);
        chk("R7 no pulse on ret", pulses - p0, 0);
    endtask

    task automatic t_irq_reti();
        int n, p0;
        irq_i = 1; two_word_i = 1; vector_i = 16'h0010; go();
        wait_idle(n);
        chk("R5 pc vector", pc_o, 16'h0010);
        chk("R5 saved low", mem[9'h1FF], 8'h36);
        chk("R5 saved high", mem[9'h1FE], 8'h12);
        step_i = 1; go();
        p0 = pulses;
        reti_i = 1; go();
        wait_idle(n);
        chk("R7 pc", pc_o, 16'h1236);
        chk("R7 pulse now", irq_en_o, 1);
        @(negedge clk);
        chk("R7 pulse ends", irq_en_o, 0);
        chk("R7 pulse count", pulses - p0, 1);
    endtask

    task automatic t_nested();
        int n;
        call_i = 1; target_i = 16'h2000; go(); wait_idle(n);
        call_i = 1; target_i = 16'h3000; go(); wait_idle(n);
        chk("R4 nested sp", sp_o, 16'h01FB);
        ret_i = 1; go(); wait_idle(n);
        chk("R6 inner ret", pc_o, 16'h2001);
        ret_i = 1; go(); wait_idle(n);
        chk("R6 outer ret", pc_o, 16'h1237);
        chk("R6 sp back", sp_o, TOP);
    endtask

    task automatic t_busy_ignore();
        int n;
        call_i = 1; target_i = 16'h0500; go();
        jump_i = 1; target_i = 16'h7777; step_i = 1; ret_i = 1;
        sp_wr_lo_i = 1; sp_wr_hi_i = 1; sp_wdata_i = 8'h00; go();
        wait_idle(n);
        chk("R9 pc after busy", pc_o, 16'h0500);
        chk("R9 sp after busy", sp_o, 16'h01FD);
        ret_i = 1; go(); wait_idle(n);
    endtask

    task automatic t_priority();
        int n;
        jump_i = 1; target_i = 16'h0A0B; go();
        irq_i = 1; call_i = 1; two_word_i = 1; vector_i = 16'h0020; target_i = 16'h0900; go();
        wait_idle(n);
        chk("R10 irq over call", pc_o, 16'h0020);
        chk("R10 irq saves unadvanced", mem[9'h1FF], 8'h0B);
        reti_i = 1; go(); wait_idle(n);
        jump_i = 1; step_i = 1; target_i = 16'h4444; go();
        chk("R10 jump over step", pc_o, 16'h4444);
        call_i = 1; ret_i = 1; target_i = 16'h5555; go(); wait_idle(n);
        chk("R10 call over ret", pc_o, 16'h5555);
        chk("R10 call sp", sp_o, 16'h01FD);
        ret_i = 1; reti_i = 1; go(); wait_idle(n);
        chk("R10 ret over reti", irq_en_o, 0);
        chk("R10 ret target", pc_o, 16'h4445);
    endtask

    task automatic t_sp_io();
        int n;
        sp_wr_lo_i = 1; sp_wdata_i = 8'h50; go();
        chk("R8 low write", sp_o, 16'h0150);
        sp_wr_hi_i = 1; sp_wdata_i = 8'h00; go();
        chk("R8 high write", sp_o, 16'h0050);
        sp_wr_hi_i = 1; sp_wdata_i = 8'h01; go();
        chk("R8 high write 2", sp_o, 16'h0150);
        jump_i = 1; target_i = 16'hBEEF; go();
        call_i = 1; target_i = 16'h0100; go(); wait_idle(n);
        chk("R8 call uses new sp lo", mem[9'h150], 8'hF0);
        chk("R8 call uses new sp hi", mem[9'h14F], 8'hBE);
        ret_i = 1; go(); wait_idle(n);
        chk("R8 ret pc", pc_o, 16'hBEF0);
        sp_wr_lo_i = 1; sp_wr_hi_i = 1; sp_wdata_i = 8'h01; go();
        sp_wr_lo_i = 1; sp_wdata_i = 8'hFF; go();
        chk("R8 restore", sp_o, TOP);
    endtask

    task automatic t_wrap();
        jump_i = 1; target_i = 16'hFFFF; go();
        step_i = 1; two_word_i = 1; go();
        chk("R2 wrap two", pc_o, 16'h0001);
        jump_i = 1; target_i = 16'hFFFF; go();
        step_i = 1; go();
        chk("R2 wrap one", pc_o, 16'h0000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_in();
        target_i = '0; vector_i = '0; sp_wdata_i = '0;
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_step();
        t_jump();
        t_call();
        t_ret();
        t_irq_reti();
        t_nested();
        t_busy_ignore();
        t_priority();
        t_sp_io();
        t_wrap();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule